// File: doc/BRIEF.md
# Multi-Channel DMA Completion Interrupt Collector

This block gathers completion pulses from a bank of DMA channel engines and turns them into one level-sensitive interrupt line. Channels come in pairs. The receive engine of pair k reports on channel 2k, and the transmit engine reports on channel 2k+1. Every completion pulse latches into a sticky status bit. Software decides which channels may raise the interrupt by writing an enable mask. A read-only pending view shows the status bits that are also enabled.

Software reaches the block through a plain 32-bit register port. The port carries an address, a write strobe, write data and combinational read data. The usual service routine runs as follows:
- Software reads the pending view.
- It writes ones back to the status register to acknowledge the channels it has serviced.
- It may rewrite the mask.

A separate address-control register holds one option bit, and the block drives that bit out as the 32-bit addressing mode for the channel engines.

Top module: `dmairq_hub`

## Requirements
- R1: A high `rx_done[k]` sets status bit 2k, and a high `tx_done[k]` sets status bit 2k+1. The bit is set from the clock edge that samples the pulse, and it reads back at offset 0x080000.
- R2: A write to offset 0x080000 clears each status bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged. Writing 0xFFFFFFFF clears every bit.
- R3: If a completion pulse and a write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R4: The enable mask at offset 0x080008 reads back the last value written to it. Bits at or above the channel count read 0.
- R5: Offset 0x080004 reads the status register ANDed with the enable mask. Writes to this offset change no register.
- R6: `irq` is high exactly when some status bit and its enable bit are both 1, and it follows register changes with no added cycle. Clearing an enable bit drops that channel's contribution but leaves its status bit unchanged.
- R7: Bit 0 of the address-control register at offset 0x000034 can be read and written, and it drives `addr32_mode`. Its other bits read 0.
- R8: A read from any other address returns 0, and a write to any other address changes no register.
- R9: After reset, status, enable and address-control are all 0, and `irq` and `addr32_mode` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done | input | NUM_PAIRS | Completion pulses from receive engines (even channels) |
| tx_done | input | NUM_PAIRS | Completion pulses from transmit engines (odd channels) |
| reg_addr | input | ADDR_W | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Level interrupt: OR of pending bits |
| addr32_mode | output | 1 | 32-bit addressing select for the channel engines |

## Verification
The status assertions assume that completion inputs are low while reset is active. They also assume that every pulse lasts a single cycle and is sampled at a clock edge. The read-view assertions assume that the register address is steady across each clock edge. The bench drives every input at the falling edge and holds both pulse vectors at zero throughout reset. Its random cycles keep the pulses sparse, and they mix status, enable, control, pending and unmapped writes. This lets collisions between a pulse and a clear occur naturally as well as in the directed cases.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

   localparam int unsigned REG_W     = 32;
   localparam int unsigned OFS_W     = 20;

   localparam logic [OFS_W-1:0] OFS_STATUS = 20'h80000;
   localparam logic [OFS_W-1:0] OFS_PEND   = 20'h80004;
   localparam logic [OFS_W-1:0] OFS_MASK   = 20'h80008;
   localparam logic [OFS_W-1:0] OFS_ACTL   = 20'h00034;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STATUS,
      SEL_PEND,
      SEL_MASK,
      SEL_ACTL
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs,
                                           input logic hi_clear);
      reg_sel_e s;
      s = SEL_NONE;
      if (hi_clear) begin
         case (ofs)
            OFS_STATUS: s = SEL_STATUS;
            OFS_PEND:   s = SEL_PEND;
            OFS_MASK:   s = SEL_MASK;
            OFS_ACTL:   s = SEL_ACTL;
            default:    s = SEL_NONE;
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/dmairq_evmap.sv
module dmairq_evmap #(
   parameter int unsigned NUM_PAIRS = 16,
   localparam int unsigned NCH = 2 * NUM_PAIRS
) (
   input  logic [NUM_PAIRS-1:0] rx_done,
   input  logic [NUM_PAIRS-1:0] tx_done,
   output logic [NCH-1:0]       ch_evt
);

   for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
      assign ch_evt[2*k]   = rx_done[k];
      assign ch_evt[2*k+1] = tx_done[k];
   end

endmodule

// File: rtl/dmairq_status.sv
module dmairq_status #(
   parameter int unsigned NCH = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] ch_evt,
   input  logic           clr_we,
   input  logic [NCH-1:0] clr_bits,
   output logic [NCH-1:0] stat
);

   for (genvar i = 0; i < NCH; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            stat[i] <= 1'b0;
         else if (ch_evt[i])
            stat[i] <= 1'b1;
         else if (clr_we && clr_bits[i])
            stat[i] <= 1'b0;
      end
   end

   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R1, R3
   evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && (ch_evt != '0) |=> ((stat & $past(ch_evt)) == $past(ch_evt)));

   // R2
   w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && clr_we |=> ((stat & $past(clr_bits & ~ch_evt)) == '0));

   // R2
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> (($past(stat) & ~($past(clr_we) ? $past(clr_bits) : '0) & ~stat) == '0));

endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl #(
   parameter int unsigned NCH = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           mask_we,
   input  logic           actl_we,
   input  logic [31:0]    wdata,
   output logic [NCH-1:0] mask,
   output logic           addr32
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         mask <= '0;
      else if (mask_we)
         mask <= wdata[NCH-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         addr32 <= 1'b0;
      else if (actl_we)
         addr32 <= wdata[0];
   end

   // R4
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we |=> $stable(mask));

   // R7
   actl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !actl_we |=> $stable(addr32));

endmodule

// File: rtl/dmairq_hub.sv
module dmairq_hub
   import dmairq_pkg::*;
#(
   parameter int unsigned NUM_PAIRS = 16,
   parameter int unsigned ADDR_W    = 20,
   parameter bit          IRQ_REG   = 1'b0,
   localparam int unsigned NCH      = 2 * NUM_PAIRS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PAIRS-1:0] rx_done,
   input  logic [NUM_PAIRS-1:0] tx_done,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_we,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   output logic                 irq,
   output logic                 addr32_mode
);

   if (NUM_PAIRS < 1 || NUM_PAIRS > 16) begin : g_bad_pairs
      $error("dmairq_hub: NUM_PAIRS must be in 1..16");
   end
   if (ADDR_W < OFS_W) begin : g_bad_addr
      $error("dmairq_hub: ADDR_W too narrow for the register offsets");
   end

   logic [NCH-1:0] ch_evt;
   logic [NCH-1:0] stat;
   logic [NCH-1:0] mask;
   logic [NCH-1:0] pend;
   logic           hi_clear;
   reg_sel_e       sel;

   if (ADDR_W > OFS_W) begin : g_hi
      assign hi_clear = (reg_addr[ADDR_W-1:OFS_W] == '0);
   end else begin : g_nohi
      assign hi_clear = 1'b1;
   end

   assign sel = decode_ofs(reg_addr[OFS_W-1:0], hi_clear);

   dmairq_evmap #(.NUM_PAIRS(NUM_PAIRS)) u_evmap (
      .rx_done (rx_done),
      .tx_done (tx_done),
      .ch_evt  (ch_evt)
   );

   dmairq_status #(.NCH(NCH)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .ch_evt   (ch_evt),
      .clr_we   (reg_we && (sel == SEL_STATUS)),
      .clr_bits (reg_wdata[NCH-1:0]),
      .stat     (stat)
   );

   dmairq_ctrl #(.NCH(NCH)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask_we (reg_we && (sel == SEL_MASK)),
      .actl_we (reg_we && (sel == SEL_ACTL)),
      .wdata   (reg_wdata),
      .mask    (mask),
      .addr32  (addr32_mode)
   );

   assign pend = stat & mask;

   always_comb begin
      case (sel)
         SEL_STATUS: reg_rdata = 32'(stat);
         SEL_PEND:   reg_rdata = 32'(pend);
         SEL_MASK:   reg_rdata = 32'(mask);
         SEL_ACTL:   reg_rdata = {31'b0, addr32_mode};
         default:    reg_rdata = '0;
      endcase
   end

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= |pend;
      end
   end else begin : g_irq_comb
      assign irq = |pend;
      // R6
      irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq == ((stat & mask) != '0));
   end

   // R5
   pend_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_PEND) |-> (reg_rdata == 32'(stat & mask)));

   // R8
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> (reg_rdata == '0));

   // R7
   actl_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_ACTL) |-> (reg_rdata[31:1] == '0));

endmodule

// File: tb/dmairq_hub_tb.sv
`timescale 1ns/1ps
module dmairq_hub_tb;
   localparam int NP = 16;
   localparam logic [19:0] A_ST = 20'h80000, A_PD = 20'h80004,
                           A_EN = 20'h80008, A_AC = 20'h00034, A_UN = 20'h80010;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [NP-1:0] rx_done = '0, tx_done = '0;
   logic [19:0]   reg_addr = '0;
   logic          reg_we = 1'b0;
   logic [31:0]   reg_wdata = '0, reg_rdata;
   logic          irq, addr32_mode;

   dmairq_hub #(.NUM_PAIRS(NP), .ADDR_W(20)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .tx_done(tx_done),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq), .addr32_mode(addr32_mode));

   int checks = 0, fails = 0;
   bit done = 0;
   logic [31:0] m_st = '0, m_en = '0;
   logic        m_ac = 1'b0;

   function automatic logic [31:0] chmap(input logic [NP-1:0] rx, input logic [NP-1:0] tx);
      logic [31:0] v = '0;
      for (int k = 0; k < NP; k++) begin
         v[2*k]   = rx[k];
         v[2*k+1] = tx[k];
      end
      return v;
   endfunction

   function automatic logic [31:0] exp_rd(input logic [19:0] a);
      case (a)
         A_ST:    return m_st;
         A_PD:    return m_st & m_en;
         A_EN:    return m_en;
         A_AC:    return {31'b0, m_ac};
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic [NP-1:0] rx, input logic [NP-1:0] tx,
                      input logic we, input logic [19:0] a, input logic [31:0] wd);
      @(negedge clk);
      rx_done = rx; tx_done = tx; reg_we = we; reg_addr = a; reg_wdata = wd;
      @(posedge clk);
      if (we && a == A_ST) m_st = m_st & ~wd;
      m_st = m_st | chmap(rx, tx);
      if (we && a == A_EN) m_en = wd;
      if (we && a == A_AC) m_ac = wd[0];
   endtask

   task automatic rd(input logic [19:0] a, input string req);
      @(negedge clk);
      rx_done = '0; tx_done = '0; reg_we = 1'b0; reg_addr = a;
      #1 chk(req, reg_rdata, exp_rd(a));
   endtask

   task automatic chk_all(input string tag);
      rd(A_ST, {tag, " R1/R2 status"});
      rd(A_PD, {tag, " R5 pending"});
      rd(A_EN, {tag, " R4 enable"});
      rd(A_AC, {tag, " R7 actl"});
      rd(A_UN, {tag, " R8 unmapped"});
      chk({tag, " R6 irq"}, {31'b0, irq}, {31'b0, |(m_st & m_en)});
      chk({tag, " R7 addr32"}, {31'b0, addr32_mode}, {31'b0, m_ac});
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL R9 watchdog act=hung exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7));
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R9 reset state
      chk_all("R9 reset");

      // R1 pair mapping
      cyc(16'h0001, '0, 0, A_UN, 0);
      rd(A_ST, "R1 rx pair0 -> ch0");
      cyc('0, 16'h8000, 0, A_UN, 0);
      rd(A_ST, "R1 tx pair15 -> ch31");

      // R6 enable then mask keeps status
      cyc('0, '0, 1, A_EN, 32'h8000_0001);
      chk_all("R6 enabled");
      cyc('0, '0, 1, A_EN, 32'h0);
      chk_all("R6 masked");

      // R2 write-1/write-0
      cyc('0, '0, 1, A_ST, 32'h0000_0001);
      rd(A_ST, "R2 w1c bit0");
      cyc('0, '0, 1, A_ST, 32'h0);
      rd(A_ST, "R2 w0 no change");
      cyc(16'h00F0, 16'h0F00, 0, A_UN, 0);
      cyc('0, '0, 1, A_ST, 32'hFFFF_FFFF);
      rd(A_ST, "R2 all ones");

      // R3 collision: rx pair2 = ch4 with clear of ch4
      cyc(16'h0004, '0, 1, A_ST, 32'h0000_0010);
      rd(A_ST, "R3 event wins");

      // R5 pending is read-only
      cyc('0, '0, 1, A_EN, 32'hFFFF_FFFF);
      cyc('0, '0, 1, A_PD, 32'hFFFF_FFFF);
      chk_all("R5 pend write");

      // R7 address control
      cyc('0, '0, 1, A_AC, 32'hFFFF_FFFF);
      chk_all("R7 set");

      // R8 unmapped write
      cyc('0, '0, 1, A_UN, 32'hFFFF_FFFF);
      cyc('0, '0, 1, 20'h80040, 32'h0);
      chk_all("R8 unmapped write");

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [NP-1:0] rx, tx;
         logic [19:0] a;
         logic [31:0] wd;
         int op;
         rx = NP'($urandom & $urandom & $urandom);
         tx = NP'($urandom & $urandom & $urandom);
         op = int'($urandom % 6);
         case (op)
            0: a = A_ST; 1: a = A_EN; 2: a = A_AC;
            3: a = A_PD; 4: a = A_UN; default: a = A_ST;
         endcase
         wd = (op == 5) ? chmap(rx, tx) | $urandom : $urandom;
         cyc(rx, tx, ($urandom % 4) != 0, a, wd);
         if (n % 4 == 3) chk_all("RND");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule